// File: doc/BRIEF.md
# Byte-Wide SPI Master with Host Register Port

This block is an SPI master that a host processor controls through six byte registers at fixed offsets. Writing a byte to the transmit register shifts that byte out on the serial data output. Writing any value to the receive register runs one byte-long transfer that gathers eight bits from the serial data input. After that, the host reads the received byte from the same register. The host finds out whether a transfer has finished by polling a status register. That register has separate flags for busy, queue full, receive-byte-ready and transmit-drained.

Transfers use SPI mode 0: the clock idles low, data is sampled on the rising edge and changes on the falling edge, and the most significant bit goes first. A 4-bit divider in the control register sets how many system clocks each clock phase lasts. Another control bit turns on a four-entry transmit queue, so the host can post several bytes without polling between them. The chip-select pin comes straight from a host-writable register bit. Misuse is never silent: it sets one of four sticky error bits, and the host clears those bits by writing ones to them.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, the registers read as follows: control (offset 2) 0x15, which is queue on and divider 5; status (offset 3) 0x10; chip select (offset 4) 0x01; error (offset 5) 0x00.
- R2: A write to offset 0 shifts the byte out on `spi_mosi`, MSB first. `spi_mosi` changes only while `spi_sck` is low, and `spi_sck` is low whenever the block is idle. Status bit 7 (busy) is set while the byte is queued or shifting. When the block is idle again, status reads 0x10.
- R3: A write of any value to offset 1 runs a receive. `spi_miso` is sampled on each rising `spi_sck` edge, MSB first. When the receive ends, busy clears, status bit 5 (ready) sets, and a read of offset 1 returns the byte. That read clears bit 5.
- R4: Each high phase and each low phase of `spi_sck` lasts D system clocks, where D is control bits 3:0. A value of 0 acts as 1.
- R5: With control bit 4 set, up to 4 transmit bytes queue and go out in the order they were written. Status bit 6 is set while 4 bytes wait. With control bit 4 clear, status bit 6 equals busy.
- R6: A transmit write made while status bit 6 is set is dropped and sets error bit 1.
- R7: A control write made while busy is dropped and sets error bit 4.
- R8: A receive started while status bit 5 is still set sets error bit 3. The receive still runs, and its byte replaces the old one.
- R9: A receive request made while busy is dropped and sets error bit 2.
- R10: Error bits stay set until the host writes a 1 to that bit at offset 5. Writing 0 to a bit leaves it unchanged.
- R11: Chip-select register bit 0 drives `spi_csn` directly, one clock after the write.
- R12: Status bits 3:0 read as 0, and offset 0 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe; a read of offset 1 clears the ready flag |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_csn | output | 1 | Active-low chip select |

## Verification
Some internal faults are visible on the serial pins within one byte time. A wrong bit or edge counter shows up as a byte on `spi_mosi` that the bench's device model captures wrongly. It also shows up as a high phase of `spi_sck` that does not last D clocks, or as a receive byte read back at offset 1 that does not match what the model drove. Faults in the queue pointers or the full logic change the order or the number of bytes the device sees after a burst. Faults in the error or ready logic appear on the next register read, as a wrong status or error value.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int BYTE_W = 8;
    localparam int DIV_W  = 4;

    // Register offsets; host software depends on these positions.
    typedef enum logic [2:0] {
        OFF_TXD = 3'd0,
        OFF_RXD = 3'd1,
        OFF_CTL = 3'd2,
        OFF_STA = 3'd3,
        OFF_CSR = 3'd4,
        OFF_ERR = 3'd5
    } reg_off_e;

    typedef struct packed {
        logic             q_en;
        logic [DIV_W-1:0] div;
    } ctl_t;

    // Error bits, held at register bits 4..1 in this order.
    typedef struct packed {
        logic ctl_while_busy;
        logic rx_overlap;
        logic rx_underrun;
        logic tx_overrun;
    } err_t;

    localparam ctl_t CTL_RESET = '{q_en: 1'b1, div: 4'd5};

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction

endpackage

// File: rtl/spi_host_clkdiv.sv
module spi_host_clkdiv
    import spi_host_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] lim;

    assign lim  = ((div == '0) ? DW'(1) : div) - DW'(1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + DW'(1);
    end
endmodule

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] fill,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    assign empty = (fill == '0);
    assign head  = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (push) begin
                mem[wp] <= din;
                wp      <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
            end
            if (pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
            fill <= fill + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine #(
    parameter int W   = 8,
    localparam int EW = $clog2(2*W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         start,
    input  logic         start_rx,
    input  logic [W-1:0] load,
    input  logic         miso,
    output logic         active,
    output logic         is_rx,
    output logic         sck,
    output logic         mosi,
    output logic         done_rx,
    output logic [W-1:0] rx_byte
);
    logic [W-1:0]  tx_sh;
    logic [EW-1:0] edges;
    logic          last;

    assign last    = tick && sck && (edges == EW'(2*W-1));
    assign done_rx = active && is_rx && last;
    assign mosi    = active & tx_sh[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            is_rx   <= 1'b0;
            sck     <= 1'b0;
            tx_sh   <= '0;
            rx_byte <= '0;
            edges   <= '0;
        end else if (!active) begin
            sck <= 1'b0;
            if (start) begin
                active <= 1'b1;
                is_rx  <= start_rx;
                tx_sh  <= load;
                edges  <= '0;
            end
        end else if (tick) begin
            edges <= edges + EW'(1);
            if (!sck) begin
                sck     <= 1'b1;
                rx_byte <= {rx_byte[W-2:0], miso};
            end else begin
                sck   <= 1'b0;
                tx_sh <= {tx_sh[W-2:0], 1'b0};
                if (last) active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [2:0]        host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_csn
);
    ctl_t              ctl_q;
    err_t              err_q, err_set, err_clr;
    logic              cs_q;
    logic              rx_ready;
    logic [BYTE_W-1:0] rx_data;

    logic [BYTE_W-1:0] head;
    logic [CW-1:0]     fill;
    logic              empty;
    logic              active, is_rx, done_rx, tick;
    logic [BYTE_W-1:0] rx_byte;

    logic wr_tx, wr_rx, wr_ctl, wr_csr, wr_err;
    logic busy, full, tx_drained, rx_go, pop;

    assign wr_tx  = host_we && (host_addr == OFF_TXD);
    assign wr_rx  = host_we && (host_addr == OFF_RXD);
    assign wr_ctl = host_we && (host_addr == OFF_CTL);
    assign wr_csr = host_we && (host_addr == OFF_CSR);
    assign wr_err = host_we && (host_addr == OFF_ERR);

    assign busy       = active | ~empty;
    assign full       = ctl_q.q_en ? (fill == CW'(DEPTH)) : busy;
    assign tx_drained = empty & ~(active & ~is_rx);
    assign rx_go      = wr_rx & ~busy;
    assign pop        = ~active & ~empty;

    assign err_set.tx_overrun     = wr_tx & full;
    assign err_set.rx_underrun    = wr_rx & busy;
    assign err_set.rx_overlap     = rx_go & rx_ready;
    assign err_set.ctl_while_busy = wr_ctl & busy;
    assign err_clr = wr_err ? err_t'(host_wdata[4:1]) : '0;

    spi_host_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (wr_tx & ~full),
        .din  (host_wdata),
        .pop  (pop),
        .head (head),
        .fill (fill),
        .empty(empty)
    );

    spi_host_clkdiv #(.DW(DIV_W)) u_div (
        .clk (clk),
        .rst (rst),
        .run (active),
        .div (ctl_q.div),
        .tick(tick)
    );

    spi_host_engine #(.W(BYTE_W)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .start   (pop | rx_go),
        .start_rx(rx_go),
        .load    (rx_go ? '0 : head),
        .miso    (spi_miso),
        .active  (active),
        .is_rx   (is_rx),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .done_rx (done_rx),
        .rx_byte (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= CTL_RESET;
            err_q    <= '0;
            cs_q     <= 1'b1;
            rx_ready <= 1'b0;
            rx_data  <= '0;
        end else begin
            if (wr_ctl && !busy) ctl_q <= ctl_t'(host_wdata[DIV_W:0]);
            if (wr_csr)          cs_q  <= host_wdata[0];
            err_q <= (err_q & ~err_clr) | err_set;
            if (done_rx) begin
                rx_data  <= rx_byte;
                rx_ready <= 1'b1;
            end else if (host_re && host_addr == OFF_RXD) begin
                rx_ready <= 1'b0;
            end
        end
    end

    assign spi_csn = cs_q;

    always_comb begin
        case (host_addr)
            OFF_RXD: host_rdata = rx_data;
            OFF_CTL: host_rdata = BYTE_W'(ctl_q);
            OFF_STA: host_rdata = {busy, full, rx_ready, tx_drained, 4'b0000};
            OFF_CSR: host_rdata = BYTE_W'(cs_q);
            OFF_ERR: host_rdata = {3'b000, err_q, 1'b0};
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk #(
    parameter int DEPTH = 4,
    localparam int CW   = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          host_we,
    input logic [2:0]    host_addr,
    input logic [7:0]    host_wdata,
    input logic [7:0]    host_rdata,
    input logic          spi_sck,
    input logic          spi_csn,
    input logic          busy,
    input logic          full,
    input logic [4:0]    ctl,
    input logic [3:0]    err,
    input logic [CW-1:0] fill
);
    logic [3:0] clr_now;
    assign clr_now = (host_we && host_addr == 3'd5) ? host_wdata[4:1] : 4'b0000;

    a_r11_cs_follows: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 3'd4) |=> (spi_csn == $past(host_wdata[0])));

    a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !spi_sck);

    a_r7_ctl_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ctl));

    a_r5_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((err & ($past(err) & ~$past(clr_now))) == ($past(err) & ~$past(clr_now))));

    a_r12_status_low_zero: assert property (@(posedge clk) disable iff (rst)
        (host_addr == 3'd3) |-> (host_rdata[3:0] == 4'b0000));

    a_r6_overrun_flag: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 3'd0 && full) |=> err[0]);
endmodule

bind spi_host_ctrl spi_host_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .spi_sck   (spi_sck),
    .spi_csn   (spi_csn),
    .busy      (busy),
    .full      (full),
    .ctl       (ctl_q),
    .err       (err_q),
    .fill      (fill)
);

// File: tb/tb_spi_host_ctrl.sv
module tb_spi_host_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0, host_re = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       spi_sck, spi_mosi, spi_miso, spi_csn;

    int errors = 0, checks = 0, cycles = 0;

    spi_host_ctrl dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_csn(spi_csn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Device model: captures MOSI on rising SCK, shifts MISO on falling SCK.
    logic [7:0] cap = 8'd0, slv = 8'd0;
    logic [7:0] caplog [32];
    int bitc = 0, ncap = 0;
    assign spi_miso = slv[7];

    always @(posedge spi_sck) begin
        cap  = {cap[6:0], spi_mosi};
        bitc = bitc + 1;
        if (bitc == 8) begin
            bitc = 0;
            if (ncap < 32) caplog[ncap] = cap;
            ncap = ncap + 1;
        end
    end
    always @(negedge spi_sck) slv = {slv[6:0], 1'b0};

    // SCK high-phase width monitor.
    int hcnt = 0, hmin = 1000, hmax = 0;
    always @(negedge clk) begin
        cycles = cycles + 1;
        if (spi_sck) hcnt = hcnt + 1;
        else if (hcnt != 0) begin
            if (hcnt < hmin) hmin = hcnt;
            if (hcnt > hmax) hmax = hcnt;
            hcnt = 0;
        end
    end

    function automatic int exp_half(input logic [3:0] d);
        return (d == 4'd0) ? 1 : int'(d);
    endfunction

    function automatic logic [7:0] exp_status(input logic b, input logic f,
                                              input logic rdy, input logic oc);
        return {b, f, rdy, oc, 4'b0000};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_re = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_re = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(3'd3, s);
            if (!s[7]) return;
        end
        chk(req, 1, 0);
    endtask

    always @(negedge clk) begin
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, b, b2;
        logic [3:0] d;
        logic [7:0] burst [5];
        int n0;
        void'($urandom(32'd7351));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(3'd2, v); chk("R1 ctl", v, 8'h15);
        rd(3'd3, v); chk("R1 status", v, exp_status(0, 0, 0, 1));
        rd(3'd4, v); chk("R1 csr", v, 8'h01);
        rd(3'd5, v); chk("R1 err", v, 8'h00);
        chk("R11 csn at reset", spi_csn, 1);

        // R11 chip select pin
        wr(3'd4, 8'hFE); chk("R11 csn low", spi_csn, 0);
        rd(3'd4, v); chk("R11 csr readback", v, 8'h00);
        wr(3'd4, 8'h01); chk("R11 csn high", spi_csn, 1);

        // R12 offset 0 reads zero
        rd(3'd0, v); chk("R12 txd read", v, 8'h00);

        // R2/R4 random transmits
        for (int i = 0; i < 6; i++) begin
            d = 4'($urandom % 6);
            wr(3'd2, {3'b000, 1'($urandom % 2), d});
            b = 8'($urandom);
            n0 = ncap; hmin = 1000; hmax = 0;
            wr(3'd0, b);
            rd(3'd3, v); chk("R2 busy during tx", v[7], 1);
            wait_idle("R2 tx timeout");
            chk("R2 one byte sent", ncap, n0 + 1);
            chk("R2 mosi byte", caplog[(ncap - 1) % 32], b);
            rd(3'd3, v); chk("R2 status idle", v, exp_status(0, 0, 0, 1));
            chk("R4 sck high min", hmin, exp_half(d));
            chk("R4 sck high max", hmax, exp_half(d));
        end

        // R3 random receives
        for (int i = 0; i < 6; i++) begin
            d = 4'($urandom % 4);
            wr(3'd2, {4'b0001, d});
            b = 8'($urandom);
            slv = b;
            wr(3'd1, 8'($urandom));
            wait_idle("R3 rx timeout");
            rd(3'd3, v); chk("R3 ready set", v, exp_status(0, 0, 1, 1));
            rd(3'd1, v); chk("R3 rx byte", v, b);
            rd(3'd3, v); chk("R3 ready cleared", v, exp_status(0, 0, 0, 1));
        end

        // R5 queue order and full flag; R6 overrun in queue mode
        wr(3'd2, 8'h14);
        n0 = ncap;
        for (int i = 0; i < 5; i++) begin
            burst[i] = 8'($urandom);
            wr(3'd0, burst[i]);
        end
        rd(3'd3, v); chk("R5 full flag", v[6], 1);
        wr(3'd0, 8'h5A);
        rd(3'd5, v); chk("R6 overrun queue", v, 8'h02);
        wait_idle("R5 burst timeout");
        chk("R5 byte count", ncap, n0 + 5);
        for (int i = 0; i < 5; i++) chk("R5 order", caplog[(n0 + i) % 32], burst[i]);

        // R10 write-one-to-clear
        wr(3'd5, 8'h00); rd(3'd5, v); chk("R10 zero write keeps", v, 8'h02);
        wr(3'd5, 8'h02); rd(3'd5, v); chk("R10 one write clears", v, 8'h00);

        // R6 overrun in single-byte mode
        wr(3'd2, 8'h01);
        n0 = ncap;
        wr(3'd0, 8'hC3);
        rd(3'd3, v); chk("R5 full equals busy", v[7:6], 2'b11);
        wr(3'd0, 8'h3C);
        rd(3'd5, v); chk("R6 overrun single", v, 8'h02);
        wait_idle("R6 timeout");
        chk("R6 dropped byte", ncap, n0 + 1);
        chk("R6 kept byte", caplog[(ncap - 1) % 32], 8'hC3);
        wr(3'd5, 8'hFF);

        // R7 control write while busy
        wr(3'd0, 8'h81);
        wr(3'd2, 8'h13);
        rd(3'd5, v); chk("R7 err flag", v, 8'h10);
        wait_idle("R7 timeout");
        rd(3'd2, v); chk("R7 ctl unchanged", v, 8'h01);
        wr(3'd5, 8'hFF);

        // R9 receive request while busy
        wr(3'd0, 8'h42);
        wr(3'd1, 8'h00);
        rd(3'd5, v); chk("R9 err flag", v, 8'h04);
        wait_idle("R9 timeout");
        rd(3'd3, v); chk("R9 no receive", v[5], 0);
        wr(3'd5, 8'hFF);

        // R8 overlap
        b = 8'($urandom); b2 = ~b;
        slv = b; wr(3'd1, 8'h00); wait_idle("R8 timeout a");
        slv = b2; wr(3'd1, 8'h00);
        rd(3'd5, v); chk("R8 overlap flag", v, 8'h08);
        wait_idle("R8 timeout b");
        rd(3'd1, v); chk("R8 newer byte", v, b2);
        rd(3'd3, v); chk("R12 status low nibble", v[3:0], 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule